// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is the host-facing serial port of a data converter. A host selects the port with an active-low chip select and toggles a serial clock. Every access opens with an 8-bit command byte that gives the direction, how many data bytes follow and the first register address. The data bytes follow, and the address steps by one after each byte. The port runs entirely on the system clock. It synchronises the chip select, the serial clock and the serial data input, then acts on the edges it detects.

A result-strobe input stands in for the converter core. The strobe loads a 24-bit conversion result into an output register, which the host sees as three read-only bytes, and drives an active-low ready flag. A host may still be reading the old result when a new one arrives. The new result is then parked in a shadow register and only takes its place once the read has ended, so the host never receives a mix of two results. Read data is returned on the bidirectional data pin (3-wire) or on a dedicated output pin (4-wire), chosen by an input.

Top module: `ser_reg_port`

## Requirements
- R1: Command byte: bit 7 = 1 reads and 0 writes; bits 6:5 hold the data byte count minus one (1 to 4 bytes); bit 4 is reserved and has no effect; bits 3:0 give the first address.
- R2: Input bits are taken on rising serial-clock edges and read bits are driven after falling edges, MSB first. The address advances by one per data byte and wraps from 15 to 0. Addresses 0..2 read result bits 23:16, 15:8 and 7:0, address 3 is the control register, and addresses 4..15 are general storage.
- R3: Writes to addresses 3..15 are stored. Writes to the result addresses 0..2 are dropped.
- R4: In 3-wire mode (`wire4`=0) read data leaves on `sdio_o` with `sdio_oe`=1 and `sdo_oe`=0. In 4-wire mode it leaves on `sdo_o` with `sdo_oe`=1 and `sdio_oe`=0. The two enables are never high together.
- R5: Both enables are low except during the data phase of a read with chip select low. Raising chip select mid-transfer aborts the access, and the next access starts again at a command byte.
- R6: With no protected read under way, a `res_valid` pulse loads `res_data` into the output register and drives `drdy_n` low on the same clock edge.
- R7: `drdy_n` returns high once the byte at address 2 has been fully shifted out by a read.
- R8: A read whose start address is 0..2 is protected until it ends. A result arriving meanwhile leaves the bytes being read untouched. When the read ends, the held result enters the output register and `drdy_n` goes low again.
- R9: Control register bit 0 sets the serial-clock idle level (1 = high). If chip select falls while the serial clock is not at that level, the whole access is ignored.
- R10: After reset `drdy_n` is high, both enables are low, and the result and control registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Data pin input side |
| sdio_o | output | 1 | Data pin output side |
| sdio_oe | output | 1 | Data pin drive enable |
| sdo_o | output | 1 | Dedicated serial output (4-wire) |
| sdo_oe | output | 1 | Dedicated output drive enable |
| wire4 | input | 1 | 1 = 4-wire, 0 = 3-wire |
| res_valid | input | 1 | New conversion result strobe |
| res_data | input | 24 | Conversion result |
| drdy_n | output | 1 | Result ready flag, active low |

## Verification
Each pin passes through two synchroniser stages and an edge register. A driven read bit is therefore valid about four system clocks after the falling serial edge that launches it. The bench holds each serial-clock half period for eight system clocks and reads the bit just before it raises the clock. `drdy_n` and the result register change on the system edge that captures `res_valid`, so the bench checks them at the following falling system edge. Flag and enable checks after an access wait a further half period or more, which covers the synchroniser and the one-cycle lag between the end of the lock and the shadow copy.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int SRP_AW = 4;

  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_INSTR = 3'd1,
    PH_DATA  = 3'd2,
    PH_DONE  = 3'd3,
    PH_SKIP  = 3'd4
  } phase_t;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import ser_reg_pkg::*;
#(
  parameter int RES_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              idle_hi,
  input  logic              wire4,
  input  logic [7:0]        rdata,
  output logic [SRP_AW-1:0] addr,
  output logic              wr_en,
  output logic [SRP_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              lock,
  output logic              res_release,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo_o,
  output logic              sdo_oe
);
  localparam logic [SRP_AW-1:0] LAST_RES = SRP_AW'(RES_BYTES - 1);

  phase_t     phase;
  logic       sclk_q;
  logic [6:0] sh;
  logic [2:0] bitcnt;
  logic [1:0] left;
  logic       rd;
  logic       load_tx;
  logic [7:0] tx_sh;
  logic       dout;
  logic       rise, fall;
  logic [7:0] byte_in;

  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign byte_in = {sh, sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_OFF;
      sclk_q      <= 1'b0;
      sh          <= '0;
      bitcnt      <= '0;
      left        <= '0;
      rd          <= 1'b0;
      addr        <= '0;
      load_tx     <= 1'b0;
      tx_sh       <= '0;
      dout        <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      lock        <= 1'b0;
      res_release <= 1'b0;
      sdio_oe     <= 1'b0;
      sdo_oe      <= 1'b0;
    end else begin
      sclk_q      <= sclk_s;
      wr_en       <= 1'b0;
      res_release <= 1'b0;
      if (load_tx) begin
        tx_sh   <= rdata;
        load_tx <= 1'b0;
      end
      if (cs_n_s) begin
        phase   <= PH_OFF;
        bitcnt  <= '0;
        lock    <= 1'b0;
        load_tx <= 1'b0;
        sdio_oe <= 1'b0;
        sdo_oe  <= 1'b0;
      end else begin
        sdio_oe <= (phase == PH_DATA) && rd && !wire4;
        sdo_oe  <= (phase == PH_DATA) && rd && wire4;
        case (phase)
          PH_OFF: begin
            bitcnt <= '0;
            phase  <= (sclk_s == idle_hi) ? PH_INSTR : PH_SKIP;
          end
          PH_INSTR, PH_DATA: begin
            if (fall && phase == PH_DATA && rd) begin
              dout  <= tx_sh[7];
              tx_sh <= {tx_sh[6:0], 1'b0};
            end
            if (rise) begin
              sh     <= byte_in[6:0];
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                if (phase == PH_INSTR) begin
                  rd      <= byte_in[7];
                  left    <= byte_in[6:5];
                  addr    <= byte_in[3:0];
                  lock    <= byte_in[7] && (byte_in[3:0] <= LAST_RES);
                  load_tx <= byte_in[7];
                  phase   <= PH_DATA;
                end else begin
                  if (rd) begin
                    res_release <= (addr == LAST_RES);
                  end else begin
                    wr_en   <= 1'b1;
                    wr_addr <= addr;
                    wr_data <= byte_in;
                  end
                  addr <= addr + 1'b1;
                  if (left == 2'd0) begin
                    phase <= PH_DONE;
                    lock  <= 1'b0;
                  end else begin
                    left    <= left - 2'd1;
                    load_tx <= rd;
                  end
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdio_o = dout;
  assign sdo_o  = dout;
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
  import ser_reg_pkg::*;
#(
  parameter int RES_BYTES = 3,
  localparam int RES_W = 8 * RES_BYTES,
  localparam int DEPTH = 1 << SRP_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SRP_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [SRP_AW-1:0] rd_addr,
  input  logic [RES_W-1:0]  res_word,
  output logic [7:0]        rdata,
  output logic              idle_hi
);
  localparam logic [SRP_AW-1:0] CTRL_ADDR = SRP_AW'(RES_BYTES);

  logic [7:0] mem [DEPTH];
  logic [7:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr > CTRL_ADDR) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == CTRL_ADDR) ctrl_q <= wr_data;
  end

  always_comb begin
    rdata = mem[rd_addr];
    if (rd_addr == CTRL_ADDR) rdata = ctrl_q;
    for (int i = 0; i < RES_BYTES; i++) begin
      if (rd_addr == SRP_AW'(i)) rdata = res_word[(RES_BYTES-1-i)*8 +: 8];
    end
  end

  assign idle_hi = ctrl_q[0];
endmodule

// File: rtl/srp_result.sv
module srp_result #(
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             lock,
  input  logic             release_i,
  output logic [RES_W-1:0] res_word,
  output logic             drdy_n
);
  logic [RES_W-1:0] shadow;
  logic             pend;
  logic             lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_word <= '0;
      shadow   <= '0;
      pend     <= 1'b0;
      lock_q   <= 1'b0;
      drdy_n   <= 1'b1;
    end else begin
      lock_q <= lock;
      if (lock_q && !lock && pend) begin
        res_word <= shadow;
        pend     <= 1'b0;
        drdy_n   <= 1'b0;
      end else if (release_i) begin
        drdy_n <= 1'b1;
      end
      if (res_valid) begin
        if (lock) begin
          shadow <= res_data;
          pend   <= 1'b1;
        end else begin
          res_word <= res_data;
          pend     <= 1'b0;
          drdy_n   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
#(
  parameter int RES_BYTES = 3,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W = 8 * RES_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe,
  output logic             sdo_o,
  output logic             sdo_oe,
  input  logic             wire4,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  output logic             drdy_n
);
  logic [2:0]        pins_s;
  logic [SRP_AW-1:0] rd_addr, wr_addr;
  logic              wr_en, idle_hi, res_lock, res_release;
  logic [7:0]        wr_data, rdata;
  logic [RES_W-1:0]  res_word;

  srp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdio_i}), .q(pins_s)
  );

  srp_ctrl #(.RES_BYTES(RES_BYTES)) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .idle_hi(idle_hi), .wire4(wire4), .rdata(rdata),
    .addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock(res_lock), .res_release(res_release),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  srp_regfile #(.RES_BYTES(RES_BYTES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .res_word(res_word), .rdata(rdata), .idle_hi(idle_hi)
  );

  srp_result #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .lock(res_lock), .release_i(res_release),
    .res_word(res_word), .drdy_n(drdy_n)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             sdio_oe,
  input logic             sdo_oe,
  input logic             res_valid,
  input logic             drdy_n,
  input logic             lock,
  input logic [RES_W-1:0] res_word
);
  p_oe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe && sdo_oe));

  p_quiet_unselected_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !sdio_oe && !sdo_oe);

  p_drdy_on_load_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid && !lock |=> !drdy_n);

  p_hold_during_read_r8: assert property (@(posedge clk) disable iff (rst)
    lock && $past(lock) |-> $stable(res_word));
endmodule

bind ser_reg_port srp_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe),
  .res_valid(res_valid), .drdy_n(drdy_n), .lock(res_lock), .res_word(res_word)
);

// File: tb/ser_reg_port_tb.sv
module ser_reg_port_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0, wire4 = 1'b0;
  logic res_valid = 1'b0;
  logic [23:0] res_data = '0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe, drdy_n;

  int checks = 0, failures = 0;
  bit done = 0;
  logic idle_b = 1'b0;
  logic [7:0] mem_m [16];
  logic [7:0] ctrl_m = 8'h00;
  logic [23:0] res_m = '0;
  logic [1:0] oe_cap;

  always #4 clk = ~clk;

  ser_reg_port u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .wire4(wire4), .res_valid(res_valid), .res_data(res_data), .drdy_n(drdy_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic din, output logic dout);
    sclk = 1'b0; sdio_i = din;
    wait_n(H);
    dout = wire4 ? sdo_o : sdio_o;
    sclk = 1'b1;
    wait_n(H);
  endtask

  task automatic byte_x(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_x(b[i], r[i]);
  endtask

  task automatic begin_cyc();
    cs_n = 1'b0; wait_n(H);
  endtask

  task automatic end_cyc();
    wait_n(H); cs_n = 1'b1; wait_n(H); sclk = idle_b; wait_n(H);
  endtask

  task automatic do_read(input logic [3:0] a, input int n, input logic rsv,
                         output logic [31:0] got);
    logic [7:0] t;
    got = '0;
    begin_cyc();
    byte_x({1'b1, 2'(n - 1), rsv, a}, t);
    oe_cap = {sdio_oe, sdo_oe};
    for (int k = 0; k < n; k++) begin
      byte_x(8'h00, t);
      got[31 - 8*k -: 8] = t;
    end
    end_cyc();
  endtask

  task automatic do_write(input logic [3:0] a, input int n, input logic [31:0] d);
    logic [7:0] t;
    begin_cyc();
    byte_x({1'b0, 2'(n - 1), 1'b0, a}, t);
    for (int k = 0; k < n; k++) byte_x(d[31 - 8*k -: 8], t);
    end_cyc();
  endtask

  task automatic pulse_result(input logic [23:0] v);
    res_data = v; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input logic [3:0] a);
    if (a < 4'd3) return res_m[(2 - a)*8 +: 8];
    if (a == 4'd3) return ctrl_m;
    return mem_m[a];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    logic [7:0] t, b0, b1, b2;
    wait_n(5);
    rst = 1'b0;
    wait_n(2);

    // R10 reset state
    chk("R10 drdy_n", {31'b0, drdy_n}, 32'd1);
    chk("R10 enables", {30'b0, sdio_oe, sdo_oe}, 32'd0);
    do_read(4'd0, 4, 1'b0, got);
    chk("R10 result+ctrl", got, 32'h0);

    // R3 general storage burst writes
    for (int a = 4; a < 16; a++) mem_m[a] = 8'((a * 29) + 7);
    for (int a = 4; a < 16; a += 4)
      do_write(4'(a), 4, {mem_m[a], mem_m[a+1], mem_m[a+2], mem_m[a+3]});

    // R2 / R4 sweep over start address, length and wire mode
    for (int s = 4; s < 16; s++) begin
      for (int n = 1; n <= 4; n++) begin
        wire4 = n[0];
        do_read(4'(s), n, 1'b0, got);
        exp = '0;
        for (int k = 0; k < n; k++) exp[31 - 8*k -: 8] = exp_byte(4'(s + k));
        chk("R2 read", got, exp);
        chk("R4 enables", {30'b0, oe_cap}, wire4 ? 32'd1 : 32'd2);
      end
    end
    wire4 = 1'b0;

    // R6 load and R2 result byte order, R7 release
    pulse_result(24'hA1B2C3); res_m = 24'hA1B2C3;
    chk("R6 drdy low", {31'b0, drdy_n}, 32'd0);
    do_read(4'd0, 3, 1'b0, got);
    chk("R2 result bytes", got, 32'hA1B2C300);
    chk("R7 drdy released", {31'b0, drdy_n}, 32'd1);

    // R8 protected read
    pulse_result(24'h123456); res_m = 24'h123456;
    chk("R6 drdy low again", {31'b0, drdy_n}, 32'd0);
    begin_cyc();
    byte_x(8'hC0, t);
    byte_x(8'h00, b0);
    pulse_result(24'h0F1E2D);
    byte_x(8'h00, b1);
    byte_x(8'h00, b2);
    end_cyc();
    chk("R8 old result intact", {8'h0, b0, b1, b2}, 32'h00123456);
    chk("R8 drdy after read", {31'b0, drdy_n}, 32'd0);
    res_m = 24'h0F1E2D;
    do_read(4'd0, 3, 1'b0, got);
    chk("R8 held result", got, 32'h0F1E2D00);
    chk("R7 drdy released", {31'b0, drdy_n}, 32'd1);

    // R3 result addresses ignore writes
    do_write(4'd1, 2, 32'h5566_0000);
    do_read(4'd0, 3, 1'b0, got);
    chk("R3 result write dropped", got, 32'h0F1E2D00);

    // R1 reserved bit
    do_read(4'd5, 2, 1'b1, got);
    chk("R1 reserved bit", got, {mem_m[5], mem_m[6], 16'h0});

    // R5 abort mid read
    begin_cyc();
    byte_x(8'hE4, t);
    for (int i = 0; i < 3; i++) bit_x(1'b0, t[0]);
    chk("R4 3-wire drive", {30'b0, sdio_oe, sdo_oe}, 32'd2);
    cs_n = 1'b1; wait_n(H);
    chk("R5 abort enables", {30'b0, sdio_oe, sdo_oe}, 32'd0);
    sclk = idle_b; wait_n(H);
    do_write(4'd6, 1, 32'h3C00_0000); mem_m[6] = 8'h3C;
    do_read(4'd6, 1, 1'b0, got);
    chk("R5 restart after abort", got, 32'h3C000000);

    // R9 idle-high operation
    do_write(4'd3, 1, 32'h0100_0000); ctrl_m = 8'h01;
    idle_b = 1'b1; sclk = 1'b1; wait_n(H);
    do_read(4'd3, 1, 1'b0, got);
    chk("R9 ctrl readback", got, 32'h01000000);
    wire4 = 1'b1;
    do_read(4'd7, 2, 1'b0, got);
    chk("R9 idle-high read", got, {mem_m[7], mem_m[8], 16'h0});
    wire4 = 1'b0;
    // R9 chip select with clock away from idle level: access ignored
    sclk = 1'b0; wait_n(H);
    begin_cyc();
    byte_x(8'h05, t);
    byte_x(8'hEE, t);
    end_cyc();
    do_read(4'd5, 1, 1'b0, got);
    chk("R9 misaligned access ignored", got, {mem_m[5], 24'h0});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule